// File: doc/BRIEF.md
# Servo Pulse Noise Filter

This block sits between a pulse-width capture stage and a motor speed stage. Each time a radio servo pulse is measured, the capture stage presents the width as one byte with a one-cycle strobe. The filter decides whether that width is a believable throttle command or noise. A believable width becomes the new command, and the filter marks it with a one-cycle accept pulse. A width that is far from the previous good command counts as a reject. Too many rejects in a row, a width outside the legal pulse range, or a latched low-supply warning all put the filter into a latched failsafe.

In failsafe the command is pinned one count below the learned stop width, which the downstream stage reads as a brake request. The bad-signal output stays high until the transmitter sends a long, unbroken run of stop-position pulses. The filter comes out of reset in failsafe, so the motor cannot start until the stick has been held at stop. A capture error from the upstream stage arms the reject counter, so that the next reject trips failsafe at once.

All outputs are registered. Each result appears on the clock edge that samples the strobe.

Top module: `srv_noise_filter`

## Requirements
- R1: After reset, `bad_sig_o` is 1, `accept_o` is 0 and `cmd_o` is 0x00.
- R2: Outside failsafe, a strobed width `w` is accepted when it lies in the legal range and satisfies `last - 0x20 <= w < last + 0x20`, where `last` is the last accepted width. `last` is 0x00 after reset and is set to the final width of a run that ends failsafe (R8). On an accept, `cmd_o` becomes `w` and `accept_o` is 1 for exactly one cycle, both on the edge that samples the strobe. An accept also clears the reject count.
- R3: Outside failsafe, a legal-range width that misses the window raises no accept and leaves `cmd_o` unchanged. It adds one to the reject count. When the count reaches 5 with no accept in between, failsafe is entered on that edge.
- R4: Outside failsafe, a strobed width of 0xFA or more, or below 0x50, enters failsafe on that edge.
- R5: A high level on `low_volt_i` in any cycle sets an internal low-supply latch. While the latch is set, a width that would be accepted enters failsafe instead.
- R6: On entry to failsafe, `cmd_o` takes the value `stop_width_i - 1` sampled on that edge, or 0x00 when `stop_width_i` is 0x00. The reject count is cleared.
- R7: While `bad_sig_o` is 1, `accept_o` stays 0 and `cmd_o` holds its value.
- R8: In failsafe, a strobed width with `0x50 <= w <= stop_width_i` adds one to the recovery count. Any other strobed width, or a high `cap_err_i`, clears that count. The 48th consecutive qualifying width clears `bad_sig_o` and sets `last` to that width.
- R9: Leaving failsafe clears the low-supply latch, unless `low_volt_i` is high in that same cycle.
- R10: Outside failsafe, a high `cap_err_i` loads the reject count with its limit. Any width strobed in that same cycle is ignored. The next reject then enters failsafe, while an accept clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_i | input | 8 | Captured pulse width |
| width_vld_i | input | 1 | One-cycle strobe qualifying `width_i` |
| stop_width_i | input | 8 | Learned stop-position width |
| low_volt_i | input | 1 | Low-supply warning, latched internally |
| cap_err_i | input | 1 | Capture stage reports a malformed pulse |
| cmd_o | output | 8 | Accepted command, or the brake value in failsafe |
| accept_o | output | 1 | One-cycle pulse when a width is accepted |
| bad_sig_o | output | 1 | Failsafe active: requests braking |

## Verification
The main function is swept over every byte value. Each sweep step starts from the same accepted centre, so each result separates three cases: a width outside the legal range, a legal width outside the window, and an accepted width. The sweep therefore pins down both window edges and both range edges.

Directed runs of reject bursts check the count. Four rejects must not trip failsafe, five in a row must, and an accept placed between rejects restarts the count. Recovery runs are broken by an over-stop width, an under-range width or a capture error one step short of the target, to show that the count restarts. Low-supply and capture-error pulses are each followed by a probe width, and the result shows whether the pulse changed the decision.

// File: rtl/srv_filt_pkg.sv
package srv_filt_pkg;

    // Default configuration of the filter
    localparam int unsigned DEF_W        = 8;
    localparam int unsigned DEF_WIN      = 32;   // half-width of the acceptance window
    localparam int unsigned DEF_MIN_W    = 80;   // lowest legal pulse width
    localparam int unsigned DEF_MAX_W    = 250;  // first illegal long pulse width
    localparam int unsigned DEF_REJ_MAX  = 5;    // consecutive rejects that trip failsafe
    localparam int unsigned DEF_REC_N    = 48;   // consecutive stop readings that recover

    // Decision taken for one cycle
    typedef enum logic [2:0] {
        EV_NONE,     // nothing strobed
        EV_TAKE,     // width accepted as new command
        EV_REJECT,   // width missed the window, below trip count
        EV_TRIP,     // enter failsafe
        EV_ARM,      // capture error arms the reject count
        EV_TALLY,    // qualifying stop reading while in failsafe
        EV_RESTART,  // failsafe recovery run broken
        EV_RECOVER   // leave failsafe
    } ev_e;

endpackage

// File: rtl/srv_range_chk.sv
module srv_range_chk #(
    parameter int unsigned W     = 8,
    parameter int unsigned MIN_W = 80,
    parameter int unsigned MAX_W = 250
) (
    input  logic [W-1:0] width_i,
    input  logic [W-1:0] stop_i,
    output logic         legal_o,
    output logic         stop_ok_o
);
    localparam logic [W:0] LO_E = (W+1)'(MIN_W);
    localparam logic [W:0] HI_E = (W+1)'(MAX_W);

    logic [W:0] w_e;
    logic [W:0] s_e;
    logic       above_floor;

    always_comb begin
        w_e         = {1'b0, width_i};
        s_e         = {1'b0, stop_i};
        above_floor = (w_e >= LO_E);
        legal_o     = above_floor && (w_e < HI_E);
        stop_ok_o   = above_floor && (w_e <= s_e);
    end
endmodule

// File: rtl/srv_win_chk.sv
module srv_win_chk #(
    parameter int unsigned W   = 8,
    parameter int unsigned WIN = 32
) (
    input  logic [W-1:0] width_i,
    input  logic [W-1:0] centre_i,
    output logic         inside_o
);
    localparam logic [W+1:0] WIN_E = (W+2)'(WIN);

    logic [W+1:0] w_e;
    logic [W+1:0] c_e;

    // extended compare: no wrap at either end of the byte range
    always_comb begin
        w_e      = {2'b00, width_i};
        c_e      = {2'b00, centre_i};
        inside_o = ((w_e + WIN_E) >= c_e) && (w_e < (c_e + WIN_E));
    end
endmodule

// File: rtl/srv_sat_cnt.sv
module srv_sat_cnt #(
    parameter int unsigned LIMIT = 5,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic [CW-1:0] cur_i,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic          inc_i,
    output logic [CW-1:0] nxt_o,
    output logic          hit_o
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    always_comb begin
        if (clr_i) begin
            nxt_o = '0;
        end else if (load_i) begin
            nxt_o = LIM;
        end else if (inc_i) begin
            nxt_o = (cur_i >= LIM) ? LIM : cur_i + 1'b1;
        end else begin
            nxt_o = cur_i;
        end
        hit_o = inc_i && !clr_i && !load_i && (nxt_o == LIM);
    end
endmodule

// File: rtl/srv_noise_filter.sv
module srv_noise_filter
    import srv_filt_pkg::*;
#(
    parameter int unsigned W       = DEF_W,
    parameter int unsigned WIN     = DEF_WIN,
    parameter int unsigned MIN_W   = DEF_MIN_W,
    parameter int unsigned MAX_W   = DEF_MAX_W,
    parameter int unsigned REJ_MAX = DEF_REJ_MAX,
    parameter int unsigned REC_N   = DEF_REC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] width_i,
    input  logic         width_vld_i,
    input  logic [W-1:0] stop_width_i,
    input  logic         low_volt_i,
    input  logic         cap_err_i,
    output logic [W-1:0] cmd_o,
    output logic         accept_o,
    output logic         bad_sig_o
);
    localparam int unsigned RW = $clog2(REJ_MAX + 1);
    localparam int unsigned CW = $clog2(REC_N + 1);

    typedef struct packed {
        logic          bad;
        logic          lv;
        logic [W-1:0]  last;
        logic [W-1:0]  cmd;
        logic          acc;
        logic [RW-1:0] rej;
        logic [CW-1:0] rec;
    } st_t;

    st_t st_q, st_d;

    logic          legal;
    logic          stop_ok;
    logic          in_win;
    logic          strobe;
    logic [RW-1:0] rej_nxt;
    logic          rej_hit;
    logic [CW-1:0] rec_nxt;
    logic          rec_hit;
    logic [W-1:0]  brake_val;
    ev_e           ev;

    // ---------------- classification helpers ----------------
    srv_range_chk #(.W(W), .MIN_W(MIN_W), .MAX_W(MAX_W)) u_range (
        .width_i   (width_i),
        .stop_i    (stop_width_i),
        .legal_o   (legal),
        .stop_ok_o (stop_ok)
    );

    srv_win_chk #(.W(W), .WIN(WIN)) u_win (
        .width_i  (width_i),
        .centre_i (st_q.last),
        .inside_o (in_win)
    );

    assign strobe = width_vld_i && !cap_err_i;

    // reject counter: counts legal out-of-window widths outside failsafe
    srv_sat_cnt #(.LIMIT(REJ_MAX), .CW(RW)) u_rej (
        .cur_i  (st_q.rej),
        .clr_i  (1'b0),
        .load_i (!st_q.bad && cap_err_i),
        .inc_i  (!st_q.bad && strobe && legal && !in_win),
        .nxt_o  (rej_nxt),
        .hit_o  (rej_hit)
    );

    // recovery counter: counts consecutive stop readings inside failsafe
    srv_sat_cnt #(.LIMIT(REC_N), .CW(CW)) u_rec (
        .cur_i  (st_q.rec),
        .clr_i  (st_q.bad && (cap_err_i || (width_vld_i && !stop_ok))),
        .load_i (1'b0),
        .inc_i  (st_q.bad && strobe && stop_ok),
        .nxt_o  (rec_nxt),
        .hit_o  (rec_hit)
    );

    // brake command: one below stop, floored at zero
    always_comb begin
        if (stop_width_i == '0) begin
            brake_val = '0;
        end else begin
            brake_val = stop_width_i - 1'b1;
        end
    end

    // ---------------- event decision ----------------
    always_comb begin
        ev = EV_NONE;
        if (!st_q.bad) begin
            if (cap_err_i) begin
                ev = EV_ARM;
            end else if (width_vld_i) begin
                if (!legal) begin
                    ev = EV_TRIP;
                end else if (in_win) begin
                    ev = st_q.lv ? EV_TRIP : EV_TAKE;
                end else begin
                    ev = rej_hit ? EV_TRIP : EV_REJECT;
                end
            end
        end else begin
            if (cap_err_i) begin
                ev = EV_RESTART;
            end else if (width_vld_i) begin
                if (!stop_ok) begin
                    ev = EV_RESTART;
                end else begin
                    ev = rec_hit ? EV_RECOVER : EV_TALLY;
                end
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d     = st_q;
        st_d.acc = 1'b0;
        unique case (ev)
            EV_TAKE: begin
                st_d.cmd  = width_i;
                st_d.last = width_i;
                st_d.acc  = 1'b1;
                st_d.rej  = '0;
            end
            EV_REJECT: begin
                st_d.rej = rej_nxt;
            end
            EV_ARM: begin
                st_d.rej = rej_nxt;
            end
            EV_TRIP: begin
                st_d.bad = 1'b1;
                st_d.cmd = brake_val;
                st_d.rej = '0;
                st_d.rec = '0;
            end
            EV_TALLY: begin
                st_d.rec = rec_nxt;
            end
            EV_RESTART: begin
                st_d.rec = rec_nxt;
            end
            EV_RECOVER: begin
                st_d.bad  = 1'b0;
                st_d.lv   = 1'b0;
                st_d.last = width_i;
                st_d.rec  = '0;
                st_d.rej  = '0;
            end
            default: begin
                st_d.rej = st_q.rej;
            end
        endcase
        if (low_volt_i) begin
            st_d.lv = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bad  <= 1'b1;
            st_q.lv   <= 1'b0;
            st_q.last <= '0;
            st_q.cmd  <= '0;
            st_q.acc  <= 1'b0;
            st_q.rej  <= '0;
            st_q.rec  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o     = st_q.cmd;
    assign accept_o  = st_q.acc;
    assign bad_sig_o = st_q.bad;

endmodule

// File: rtl/srv_filter_chk.sv
module srv_filter_chk #(
    parameter int unsigned W     = 8,
    parameter int unsigned MIN_W = 80,
    parameter int unsigned MAX_W = 250
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] width_i,
    input logic         width_vld_i,
    input logic [W-1:0] stop_width_i,
    input logic         cap_err_i,
    input logic [W-1:0] cmd_o,
    input logic         accept_o,
    input logic         bad_sig_o
);
    localparam logic [W:0] LO_E = (W+1)'(MIN_W);
    localparam logic [W:0] HI_E = (W+1)'(MAX_W);

    logic [W-1:0] brake_ref;
    always_comb begin
        brake_ref = (stop_width_i == '0) ? '0 : (stop_width_i - 1'b1);
    end

    logic illegal_w;
    always_comb begin
        illegal_w = ({1'b0, width_i} < LO_E) || ({1'b0, width_i} >= HI_E);
    end

    // R2
    accept_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> ($past(width_vld_i) && (cmd_o == $past(width_i))));

    // R4
    range_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_sig_o && width_vld_i && !cap_err_i && illegal_w) |=> bad_sig_o);

    // R6
    brake_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_sig_o) |-> (cmd_o == $past(brake_ref)));

    // R7
    no_accept_in_failsafe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_sig_o |-> !accept_o);

    // R7
    cmd_hold_in_failsafe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_sig_o && $past(bad_sig_o)) |-> $stable(cmd_o));

    // R8
    recover_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bad_sig_o) |-> ($past(width_vld_i) && !$past(cap_err_i)));

endmodule

bind srv_noise_filter srv_filter_chk #(
    .W(W), .MIN_W(MIN_W), .MAX_W(MAX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .width_i      (width_i),
    .width_vld_i  (width_vld_i),
    .stop_width_i (stop_width_i),
    .cap_err_i    (cap_err_i),
    .cmd_o        (cmd_o),
    .accept_o     (accept_o),
    .bad_sig_o    (bad_sig_o)
);

// File: tb/sim_srv_noise_filter.sv
`timescale 1ns/1ps
module sim_srv_noise_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] width_i = 8'h00;
    logic       width_vld_i = 1'b0;
    logic [7:0] stop_width_i = 8'h90;
    logic       low_volt_i = 1'b0;
    logic       cap_err_i = 1'b0;
    logic [7:0] cmd_o;
    logic       accept_o;
    logic       bad_sig_o;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    srv_noise_filter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .width_i      (width_i),
        .width_vld_i  (width_vld_i),
        .stop_width_i (stop_width_i),
        .low_volt_i   (low_volt_i),
        .cap_err_i    (cap_err_i),
        .cmd_o        (cmd_o),
        .accept_o     (accept_o),
        .bad_sig_o    (bad_sig_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] w);
        @(negedge clk);
        width_i = w;
        width_vld_i = 1'b1;
        @(negedge clk);
        width_vld_i = 1'b0;
    endtask

    task automatic send_err(input logic [7:0] w);
        @(negedge clk);
        width_i = w;
        width_vld_i = 1'b1;
        cap_err_i = 1'b1;
        @(negedge clk);
        width_vld_i = 1'b0;
        cap_err_i = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk);
        cap_err_i = 1'b1;
        @(negedge clk);
        cap_err_i = 1'b0;
    endtask

    task automatic pulse_lv();
        @(negedge clk);
        low_volt_i = 1'b1;
        @(negedge clk);
        low_volt_i = 1'b0;
    endtask

    // 47 qualifying widths keep failsafe, the 48th ends it (R8)
    task automatic recover(input logic [7:0] v, input logic [7:0] exp_cmd);
        for (int i = 0; i < 47; i++) send(v);
        check("R8 still failsafe after 47", bad_sig_o, 1);
        check("R7 cmd held during recovery", cmd_o, exp_cmd);
        check("R7 no accept during recovery", accept_o, 0);
        send(v);
        check("R8 failsafe cleared on 48th", bad_sig_o, 0);
        check("R8 no accept on recovery", accept_o, 0);
    endtask

    task automatic force_bad();
        send(8'h20);
        check("R4 low width trips", bad_sig_o, 1);
        check("R6 brake value", cmd_o, 8'h8F);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 bad after reset", bad_sig_o, 1);
        check("R1 accept after reset", accept_o, 0);
        check("R1 cmd after reset", cmd_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 bad held", bad_sig_o, 1);

        recover(8'h80, 8'h00);

        // R2 R3 R4 sweep over every width from centre 0x80
        for (int w = 0; w < 256; w++) begin
            bit legal;
            bit inwin;
            force_bad();
            recover(8'h80, 8'h8F);
            send(8'(w));
            legal = (w >= 8'h50) && (w < 8'hFA);
            inwin = (w >= 8'h60) && (w < 8'hA0);
            check("R4 sweep bad", bad_sig_o, legal ? 0 : 1);
            check("R2 sweep accept", accept_o, (legal && inwin) ? 1 : 0);
            check("R2 R3 sweep cmd", cmd_o, (legal && inwin) ? w : 8'h8F);
        end

        // R2 accept pulse is one cycle wide
        force_bad();
        recover(8'h80, 8'h8F);
        send(8'h84);
        check("R2 accept", accept_o, 1);
        @(negedge clk);
        check("R2 accept one cycle", accept_o, 0);
        check("R2 cmd kept", cmd_o, 8'h84);

        // R3 four rejects, accept, four rejects: no trip
        for (int i = 0; i < 4; i++) send(8'hC0);
        check("R3 four rejects no trip", bad_sig_o, 0);
        check("R3 cmd unchanged", cmd_o, 8'h84);
        send(8'h86);
        check("R3 accept clears count", accept_o, 1);
        for (int i = 0; i < 4; i++) send(8'hC0);
        check("R3 count restarted", bad_sig_o, 0);
        send(8'hC0);
        check("R3 fifth reject trips", bad_sig_o, 1);
        check("R6 brake after rejects", cmd_o, 8'h8F);

        // R10 capture error arms the count
        recover(8'h80, 8'h8F);
        pulse_err();
        check("R10 error alone no trip", bad_sig_o, 0);
        send(8'hC0);
        check("R10 reject after error trips", bad_sig_o, 1);
        recover(8'h80, 8'h8F);
        pulse_err();
        send(8'h82);
        check("R10 accept after error", accept_o, 1);
        send(8'hC0);
        check("R10 accept cleared armed count", bad_sig_o, 0);
        recover_from_normal();
        send_err(8'h00);
        check("R10 width with error ignored", bad_sig_o, 0);
        check("R10 no accept with error", accept_o, 0);
        send(8'hC0);
        check("R10 armed by error with strobe", bad_sig_o, 1);

        // R5 low-voltage latch, R9 cleared by recovery
        recover(8'h80, 8'h8F);
        pulse_lv();
        check("R5 latch alone no trip", bad_sig_o, 0);
        send(8'h82);
        check("R5 low voltage trips", bad_sig_o, 1);
        check("R5 no accept", accept_o, 0);
        recover(8'h80, 8'h8F);
        send(8'h82);
        check("R9 latch cleared", accept_o, 1);
        check("R9 still normal", bad_sig_o, 0);

        // R8 broken runs
        force_bad();
        for (int i = 0; i < 47; i++) send(8'h80);
        send(8'h95);
        recover(8'h80, 8'h8F);
        force_bad();
        for (int i = 0; i < 30; i++) send(8'h80);
        send(8'h4F);
        recover(8'h80, 8'h8F);
        force_bad();
        for (int i = 0; i < 47; i++) send(8'h80);
        pulse_err();
        recover(8'h80, 8'h8F);
        // R8 width equal to stop qualifies; window recentred on it
        force_bad();
        recover(8'h90, 8'h8F);
        send(8'hAF);
        check("R8 recentred window", accept_o, 1);

        // R6 stop width zero floors brake value
        stop_width_i = 8'h00;
        send(8'hFF);
        check("R6 trip stop zero", bad_sig_o, 1);
        check("R6 brake floor", cmd_o, 0);
        stop_width_i = 8'h90;
        recover(8'h80, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic recover_from_normal();
        force_bad();
        recover(8'h80, 8'h8F);
    endtask

endmodule